// File: doc/BRIEF.md
# Tiled View Address Generator

This block maps a pixel position inside a two-dimensional tiled container to the 32-bit address a client issues for one view of that container. A request carries a pixel format code, a 3-bit view code, and X and Y pixel coordinates. The block mirrors each axis inside its legal range as the view code asks, and transposes the two axes for the quarter-turn views. It packs the result into a linear index whose layout depends on the format, then tags the top address bits with the view and format codes. Alongside the address it returns the line stride for that view and a flag for coordinates that fall outside the container.

The container is 2^14 pixels wide and 2^13 lines tall for 8-bit pixels. Wider pixels drop low coordinate bits: 16-bit pixels lose one Y bit, and 32-bit pixels lose one X bit and one Y bit. As a result, the shifted index always fills bits [26:0]. A parameter selects a purely combinational path or one register stage. In both cases a valid strobe travels with the outputs.

Top module: `tiled_view_addr`

## Requirements
- R1: For a valid request, address bits [28:27] equal the format code: 0 is 8-bit, 1 is 16-bit and 2 is 32-bit.
- R2: For a valid request, address bits [31:29] equal the 3-bit view code. Code bit 0 requests X mirroring, bit 1 requests Y mirroring and bit 2 requests axis transposition: 0 upright, 3 half turn, 5 and 6 quarter turns, and the other codes are their mirrored forms.
- R3: The usable X width is 14 minus xs and the usable Y width is 13 minus ys. Here (xs,ys) is (0,0) for 8-bit, (0,1) for 16-bit and (1,1) for 32-bit. The linear index is shifted left by xs+ys into bits [26:0], so its low xs+ys bits are zero.
- R4: An X above 2^(14-xs)-1 or a Y above 2^(13-ys)-1 raises the invalid flag. The address and the stride are then zero.
- R5: Format code 3 is reserved. It always raises the invalid flag, with a zero address and a zero stride.
- R6: With view bit 0 set, X is replaced by (2^(14-xs)-1) - X before packing.
- R7: With view bit 1 set, Y is replaced by (2^(13-ys)-1) - Y before packing.
- R8: With view bit 2 clear, the index is (Y << (14-xs)) + X. With it set, the index is (X << (13-ys)) + Y. Both use the mirrored coordinates.
- R9: For a valid request, the stride is 1 << (13+xs) when view bit 2 is set, and 1 << (14+ys) otherwise.
- R10: With the register stage enabled, the outputs for a request appear one clock after it, and the valid output is high in that cycle. Without the register stage, the outputs follow the inputs in the same cycle, and the valid output equals the request input.
- R11: With the register stage enabled, a cycle with the request low drops the valid output on the next clock, and the address, stride and flag outputs hold their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe for the inputs of this cycle |
| fmt_i | input | 2 | Pixel format code |
| view_i | input | 3 | View code (bit 0 X mirror, bit 1 Y mirror, bit 2 transpose) |
| x_i | input | 14 | Pixel X coordinate |
| y_i | input | 13 | Pixel Y coordinate |
| vld_o | output | 1 | Outputs carry a result |
| addr_o | output | 32 | Tagged tiled address |
| stride_o | output | 32 | Line stride of the view |
| bad_o | output | 1 | Coordinate out of range or reserved format |

## Verification
The bench builds the block twice with the default 14-by-13-bit container: once with the register stage and once without it. Both copies receive the same stimulus, which checks the one-cycle latency and the hold behaviour against the same-cycle path. The default widths make every format's range edge reachable with the full port range. The limits are X of 8191 versus 8192 for 32-bit pixels and Y of 4095 versus 4096 for 16-bit and 32-bit pixels. Random coordinates therefore land on both sides of each limit.

// File: rtl/tv_pkg.sv
package tv_pkg;

  typedef enum logic [1:0] {
    PIX8  = 2'd0,
    PIX16 = 2'd1,
    PIX32 = 2'd2,
    PIXRS = 2'd3
  } pix_fmt_e;

  typedef struct packed {
    logic swap;
    logic ymir;
    logic xmir;
  } view_ctl_t;

endpackage

// File: rtl/tv_view_decode.sv
module tv_view_decode
  import tv_pkg::*;
(
  input  logic [2:0] view_i,
  output view_ctl_t  ctl_o
);

  always_comb begin
    case (view_i)
      3'd0:    ctl_o = '{swap: 1'b0, ymir: 1'b0, xmir: 1'b0};
      3'd1:    ctl_o = '{swap: 1'b0, ymir: 1'b0, xmir: 1'b1};
      3'd2:    ctl_o = '{swap: 1'b0, ymir: 1'b1, xmir: 1'b0};
      3'd3:    ctl_o = '{swap: 1'b0, ymir: 1'b1, xmir: 1'b1};
      3'd4:    ctl_o = '{swap: 1'b1, ymir: 1'b0, xmir: 1'b0};
      3'd5:    ctl_o = '{swap: 1'b1, ymir: 1'b0, xmir: 1'b1};
      3'd6:    ctl_o = '{swap: 1'b1, ymir: 1'b1, xmir: 1'b0};
      default: ctl_o = '{swap: 1'b1, ymir: 1'b1, xmir: 1'b1};
    endcase
  end

endmodule

// File: rtl/tv_coord_pack.sv
module tv_coord_pack
  import tv_pkg::*;
#(
  parameter int XW = 14,
  parameter int YW = 13
) (
  input  logic [1:0]      fmt_i,
  input  view_ctl_t       ctl_i,
  input  logic [XW-1:0]   x_i,
  input  logic [YW-1:0]   y_i,
  output logic [XW+YW-1:0] idx_o,
  output logic            bad_o
);

  localparam int IW = XW + YW;

  logic          xs, ys, fmt_ok;
  logic [XW-1:0] xmask, xx;
  logic [YW-1:0] ymask, yy;
  logic [IW-1:0] lin;

  always_comb begin
    case (pix_fmt_e'(fmt_i))
      PIX8:    begin xs = 1'b0; ys = 1'b0; fmt_ok = 1'b1; end
      PIX16:   begin xs = 1'b0; ys = 1'b1; fmt_ok = 1'b1; end
      PIX32:   begin xs = 1'b1; ys = 1'b1; fmt_ok = 1'b1; end
      default: begin xs = 1'b0; ys = 1'b0; fmt_ok = 1'b0; end
    endcase
  end

  assign xmask = {XW{1'b1}} >> xs;
  assign ymask = {YW{1'b1}} >> ys;
  assign bad_o = !fmt_ok || (x_i > xmask) || (y_i > ymask);

  assign xx = ctl_i.xmir ? (xmask - x_i) : x_i;
  assign yy = ctl_i.ymir ? (ymask - y_i) : y_i;

  always_comb begin
    if (ctl_i.swap)
      lin = (IW'(xx) << (YW - 32'(ys))) | IW'(yy);
    else
      lin = (IW'(yy) << (XW - 32'(xs))) | IW'(xx);
  end

  assign idx_o = bad_o ? '0 : (lin << (32'(xs) + 32'(ys)));

endmodule

// File: rtl/tv_stride_calc.sv
module tv_stride_calc
  import tv_pkg::*;
#(
  parameter int XW = 14,
  parameter int YW = 13,
  parameter int AW = 32
) (
  input  logic [1:0]    fmt_i,
  input  logic          swap_i,
  output logic [AW-1:0] stride_o
);

  logic xs, ys;

  assign xs = (fmt_i == PIX32);
  assign ys = (fmt_i == PIX16) || (fmt_i == PIX32);

  always_comb begin
    if (swap_i)
      stride_o = AW'(1) << (YW + 32'(xs));
    else
      stride_o = AW'(1) << (XW + 32'(ys));
  end

endmodule

// File: rtl/tiled_view_addr.sv
module tiled_view_addr
  import tv_pkg::*;
#(
  parameter int XW      = 14,
  parameter int YW      = 13,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_i,
  input  logic [1:0]          fmt_i,
  input  logic [2:0]          view_i,
  input  logic [XW-1:0]       x_i,
  input  logic [YW-1:0]       y_i,
  output logic                vld_o,
  output logic [XW+YW+4:0]    addr_o,
  output logic [XW+YW+4:0]    stride_o,
  output logic                bad_o
);

  localparam int IW = XW + YW;
  localparam int AW = IW + 5;

  view_ctl_t     ctl;
  logic [IW-1:0] idx;
  logic          bad_c;
  logic [AW-1:0] addr_c, stride_raw, stride_c;

  tv_view_decode u_dec (
    .view_i (view_i),
    .ctl_o  (ctl)
  );

  tv_coord_pack #(.XW(XW), .YW(YW)) u_pack (
    .fmt_i (fmt_i),
    .ctl_i (ctl),
    .x_i   (x_i),
    .y_i   (y_i),
    .idx_o (idx),
    .bad_o (bad_c)
  );

  tv_stride_calc #(.XW(XW), .YW(YW), .AW(AW)) u_stride (
    .fmt_i    (fmt_i),
    .swap_i   (ctl.swap),
    .stride_o (stride_raw)
  );

  assign addr_c   = bad_c ? '0 : {view_i, fmt_i, idx};
  assign stride_c = bad_c ? '0 : stride_raw;

  generate
    if (REG_OUT) begin : g_reg
      logic          vld_q, vld_d, bad_q, bad_d;
      logic [AW-1:0] addr_q, addr_d, strd_q, strd_d;

      always_comb begin
        vld_d  = req_i;
        addr_d = addr_q;
        strd_d = strd_q;
        bad_d  = bad_q;
        if (req_i) begin
          addr_d = addr_c;
          strd_d = stride_c;
          bad_d  = bad_c;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q  <= 1'b0;
          addr_q <= '0;
          strd_q <= '0;
          bad_q  <= 1'b0;
        end else begin
          vld_q  <= vld_d;
          addr_q <= addr_d;
          strd_q <= strd_d;
          bad_q  <= bad_d;
        end
      end

      assign vld_o    = vld_q;
      assign addr_o   = addr_q;
      assign stride_o = strd_q;
      assign bad_o    = bad_q;

      // R10
      req_to_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> vld_o);
      // R11
      idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> (!vld_o && $stable(addr_o) && $stable(stride_o) && $stable(bad_o)));
    end else begin : g_comb
      assign vld_o    = req_i;
      assign addr_o   = addr_c;
      assign stride_o = stride_c;
      assign bad_o    = bad_c;
    end
  endgenerate

  // R4
  bad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && bad_o) |-> (addr_o == '0 && stride_o == '0));
  // R5
  fmt_tag_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && !bad_o) |-> (addr_o[IW+1:IW] != 2'b11));
  // R9
  stride_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && !bad_o) |-> ($countones(stride_o) == 1));
  // R3
  low_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && !bad_o && addr_o[IW+1:IW] == 2'd2) |-> (addr_o[1:0] == 2'b00));
  // R3
  half_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && !bad_o && addr_o[IW+1:IW] == 2'd1) |-> (addr_o[0] == 1'b0));

endmodule

// File: tb/tiled_view_addr_test.sv
module tiled_view_addr_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [1:0]  fmt = '0;
  logic [2:0]  view = '0;
  logic [13:0] x = '0;
  logic [12:0] y = '0;

  logic        vld_r, bad_r, vld_c, bad_c;
  logic [31:0] addr_r, strd_r, addr_c, strd_c;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  tiled_view_addr #(.REG_OUT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .fmt_i(fmt), .view_i(view),
    .x_i(x), .y_i(y), .vld_o(vld_r), .addr_o(addr_r), .stride_o(strd_r), .bad_o(bad_r));

  tiled_view_addr #(.REG_OUT(1'b0)) uut_comb (
    .clk(clk), .rst_n(rst_n), .req_i(req), .fmt_i(fmt), .view_i(view),
    .x_i(x), .y_i(y), .vld_o(vld_c), .addr_o(addr_c), .stride_o(strd_c), .bad_o(bad_c));

  function automatic void model(input logic [1:0] f, input logic [2:0] v,
                                input int unsigned xi, input int unsigned yi,
                                output logic [31:0] a, output logic [31:0] s,
                                output logic b);
    int unsigned xs, ys, xm, ym, xx, yy, lin;
    xs = (f == 2) ? 1 : 0;
    ys = (f == 1 || f == 2) ? 1 : 0;
    xm = (1 << (14 - xs)) - 1;
    ym = (1 << (13 - ys)) - 1;
    b = (f == 3) || (xi > xm) || (yi > ym);
    if (b) begin
      a = 0; s = 0;
    end else begin
      xx = v[0] ? xm - xi : xi;
      yy = v[1] ? ym - yi : yi;
      lin = v[2] ? ((xx << (13 - ys)) + yy) : ((yy << (14 - xs)) + xx);
      lin = lin << (xs + ys);
      a = {v, f, lin[26:0]};
      s = v[2] ? (32'd1 << (13 + xs)) : (32'd1 << (14 + ys));
    end
  endfunction

  task automatic check(input string tag, input logic got_v, input logic [31:0] got_a,
                       input logic [31:0] got_s, input logic got_b,
                       input logic [31:0] ea, input logic [31:0] es, input logic eb);
    n_chk++;
    if (got_v !== 1'b1 || got_a !== ea || got_s !== es || got_b !== eb) begin
      n_fail++;
      $display("FAIL %s fmt=%0d view=%0d x=%0d y=%0d: got v=%b a=%h s=%h b=%b exp v=1 a=%h s=%h b=%b",
               tag, fmt, view, x, y, got_v, got_a, got_s, got_b, ea, es, eb);
    end
  endtask

  task automatic apply(input string tag, input logic [1:0] f, input logic [2:0] v,
                       input int unsigned xi, input int unsigned yi);
    logic [31:0] ea, es;
    logic eb;
    @(negedge clk);
    req = 1'b1; fmt = f; view = v; x = xi[13:0]; y = yi[12:0];
    model(f, v, xi, yi, ea, es, eb);
    #1;
    check({tag, " comb R10"}, vld_c, addr_c, strd_c, bad_c, ea, es, eb);
    @(posedge clk);
    #1;
    check({tag, " reg R10"}, vld_r, addr_r, strd_r, bad_r, ea, es, eb);
  endtask

  initial begin : watchdog
    #400000;
    n_fail++;
    $display("FAIL watchdog: run did not complete, got timeout exp completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] hold_a;
    int unsigned seed;
    seed = $urandom(20240611);
    #9;
    n_chk++;
    if (vld_r !== 1'b0 || addr_r !== 32'd0 || bad_r !== 1'b0) begin
      n_fail++;
      $display("FAIL reset R10: got v=%b a=%h b=%b exp v=0 a=0 b=0", vld_r, addr_r, bad_r);
    end
    rst_n = 1'b1;

    // R1 R2 R8: origin, tags only
    apply("R1", 2'd1, 3'd0, 0, 0);
    apply("R2", 2'd0, 3'd5, 0, 0);
    apply("R8", 2'd0, 3'd0, 3, 2);
    apply("R8", 2'd0, 3'd4, 3, 2);
    // R6 R7 mirrors
    apply("R6", 2'd0, 3'd1, 5, 7);
    apply("R7", 2'd1, 3'd2, 5, 7);
    apply("R6", 2'd2, 3'd3, 100, 200);
    apply("R3", 2'd2, 3'd7, 8191, 4095);
    // R4 range edges
    apply("R4", 2'd2, 3'd0, 8192, 0);
    apply("R4", 2'd1, 3'd0, 0, 4096);
    apply("R4", 2'd0, 3'd6, 16383, 8191);
    apply("R4", 2'd2, 3'd6, 0, 4096);
    // R5 reserved format
    apply("R5", 2'd3, 3'd0, 1, 1);
    // R9 strides per format and transposition
    for (int f = 0; f < 3; f++)
      for (int v = 0; v < 8; v++)
        apply("R9", f[1:0], v[2:0], 17, 9);

    // R11: idle cycle holds outputs
    hold_a = addr_r;
    @(negedge clk);
    req = 1'b0; x = 14'h1234; view = 3'd7;
    @(posedge clk);
    #1;
    n_chk++;
    if (vld_r !== 1'b0 || addr_r !== hold_a) begin
      n_fail++;
      $display("FAIL R11 idle: got v=%b a=%h exp v=0 a=%h", vld_r, addr_r, hold_a);
    end

    for (int i = 0; i < 3000; i++) begin
      int unsigned rf, rv, rx, ry;
      rf = $urandom % 4;
      rv = $urandom % 8;
      rx = $urandom % 16384;
      ry = $urandom % 8192;
      apply("R3", rf[1:0], rv[2:0], rx, ry);
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule